// File: doc/BRIEF.md
# Asynchronous ROM Read Cycle Controller

This block is a clocked host-side sequencer that runs read cycles against external byte-wide asynchronous memories. Each memory has its own active-low chip-enable, and all of them share one active-low output-enable that acts as the system read strobe. A request carries a host address. Its upper bits choose the device and its lower bits go out on the memory address bus. The controller pulls the chosen chip-enable low and holds back the shared output-enable for as long as the timing slack allows. It latches the data bus in the cycle after the later access deadline and returns the byte with a one-cycle valid pulse.

All timing is given as picosecond parameters: address access, chip-enable access, output-enable access, output float and clock period. Package functions turn these into cycle counts by rounding up. The output-enable lead is the chip-enable deadline minus the output-enable delay, and it is floored at zero. When the strobes are released, the controller stays busy for the float interval so that the bus is quiet before the next cycle begins. A ready/busy pair forms the handshake. A request is taken only in a cycle where ready is high.

Top module: `romrd_ctrl`

## Requirements
- R1: After reset, ready is 1, every chip-enable is high, output-enable is high, rvalid is 0 and rdata is 0.
- R2: A request is accepted on a clock edge where req and ready are both 1, and ready is 0 from the next cycle on. A request raised while ready is 0 starts no cycle, even if req is later held.
- R3: The chip-enable that goes low is the one whose index equals the host address bits above the ADDR_W low bits. It goes low in the cycle after acceptance, and no other chip-enable goes low. mem_addr equals the low ADDR_W address bits and stays stable while a chip-enable is low.
- R4: Output-enable goes low LEAD cycles after chip-enable. LEAD is max(NACC, NCE) − NOE, floored at 0, where each N is ceil(t_ps / CLK_PS).
- R5: The strobes stay low for ACT = max(NACC, NCE) + 1 cycles. The data bus is captured on the edge that releases both strobes, and rvalid is 1 for exactly that one following cycle, with rdata holding the byte.
- R6: ready returns to 1 exactly NDF = ceil(T_DF_PS / CLK_PS) cycles after rvalid (at least 1), and no strobe is low in between.
- R7: rdata keeps the captured byte until the next capture.
- R8: Output-enable is never low unless a chip-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request |
| req_addr | input | HADDR_W | Host address: device index above ADDR_W low bits |
| ready | output | 1 | Controller idle, request may be taken |
| rvalid | output | 1 | One-cycle pulse: rdata holds a fresh byte |
| rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | NDEV | Per-device active-low chip-enable |
| mem_oe_n | output | 1 | Shared active-low output-enable |
| mem_d | input | DATA_W | Memory data bus |

## Verification
The bench models a memory that shows correct data only after chip-enable has been low for NACC counted edges and output-enable for NOE counted edges, and shows the inverted byte otherwise. A controller that samples one cycle early, or drops output-enable one cycle late, therefore returns a wrong byte. Every address of both devices is read, and each cycle of each read is checked for strobe shape, device selection and ready timing. A float interval that is one cycle too short shows up as an early ready. A request held while the controller is busy must not start a second cycle. A wrong device decode drives the other chip-enable low.

// File: rtl/romrd_pkg.sv
package romrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } seq_state_e;

  // whole clock cycles needed to cover a delay, rounded up
  function automatic int ceil_cycles(input int t_ps, input int clk_ps);
    if (clk_ps <= 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles output-enable may trail chip-enable without losing access time
  function automatic int oe_lead(input int n_acc, input int n_ce, input int n_oe);
    int d;
    d = max2(n_acc, n_ce);
    return (n_oe >= d) ? 0 : d - n_oe;
  endfunction

  // cycles the strobes are held low: deadline plus one sampling cycle
  function automatic int act_cycles(input int n_acc, input int n_ce);
    return max2(n_acc, n_ce) + 1;
  endfunction

endpackage

// File: rtl/romrd_seq.sv
module romrd_seq
  import romrd_pkg::*;
#(
  parameter int ACT_CYC   = 7,
  parameter int LEAD_CYC  = 3,
  parameter int FLOAT_CYC = 3,
  localparam int CNT_W    = $clog2(max2(ACT_CYC, FLOAT_CYC) + 1),
  localparam int LEAD_M1  = (LEAD_CYC > 0) ? LEAD_CYC - 1 : 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ready,
  output logic ce_act,
  output logic oe_act,
  output logic acc_start,
  output logic smp_evt,
  output logic float_done
);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign ready      = (state == ST_IDLE);
  assign acc_start  = req && ready;
  assign smp_evt    = (state == ST_ACCESS) && (cnt == CNT_W'(ACT_CYC - 1));
  assign float_done = (state == ST_FLOAT) && (cnt == CNT_W'(FLOAT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ce_act <= 1'b0;
      oe_act <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (acc_start) begin
            state  <= ST_ACCESS;
            cnt    <= '0;
            ce_act <= 1'b1;
            oe_act <= (LEAD_CYC == 0);
          end
        end
        ST_ACCESS: begin
          if (smp_evt) begin
            state  <= ST_FLOAT;
            cnt    <= '0;
            ce_act <= 1'b0;
            oe_act <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            if ((LEAD_CYC > 0) && (cnt == CNT_W'(LEAD_M1))) oe_act <= 1'b1;
          end
        end
        ST_FLOAT: begin
          if (float_done) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          cnt    <= '0;
          ce_act <= 1'b0;
          oe_act <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/romrd_cs_decode.sv
module romrd_cs_decode #(
  parameter int NDEV  = 2,
  localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic             ce_act,
  input  logic [SEL_W-1:0] dev_sel,
  output logic [NDEV-1:0]  ce_n
);

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    assign ce_n[g] = !(ce_act && (dev_sel == SEL_W'(g)));
  end

endmodule

// File: rtl/romrd_capture.sv
module romrd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_evt,
  input  logic [DATA_W-1:0] mem_d,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= smp_evt;
      if (smp_evt) rdata <= mem_d;
    end
  end

endmodule

// File: rtl/romrd_ctrl.sv
module romrd_ctrl
  import romrd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int NDEV      = 2,
  parameter int CLK_PS    = 20000,
  parameter int T_ACC_PS  = 120000,
  parameter int T_CE_PS   = 120000,
  parameter int T_OE_PS   = 50000,
  parameter int T_DF_PS   = 45000,
  localparam int SEL_W    = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int HADDR_W  = (NDEV > 1) ? ADDR_W + SEL_W : ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [HADDR_W-1:0] req_addr,
  output logic               ready,
  output logic               rvalid,
  output logic [DATA_W-1:0]  rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [NDEV-1:0]    mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DATA_W-1:0]  mem_d
);

  localparam int NACC      = ceil_cycles(T_ACC_PS, CLK_PS);
  localparam int NCE       = ceil_cycles(T_CE_PS, CLK_PS);
  localparam int NOE       = ceil_cycles(T_OE_PS, CLK_PS);
  localparam int NDF       = ceil_cycles(T_DF_PS, CLK_PS);
  localparam int LEAD_CYC  = oe_lead(NACC, NCE, NOE);
  localparam int ACT_CYC   = act_cycles(NACC, NCE);
  localparam int FLOAT_CYC = (NDF < 1) ? 1 : NDF;

  // internal events, brought out by name for the checker
  logic             acc_start;
  logic             smp_evt;
  logic             float_done;
  logic             ce_act;
  logic             oe_act;
  logic [SEL_W-1:0] dev_q;
  logic [SEL_W-1:0] dev_in;

  if (NDEV > 1) begin : g_multi
    assign dev_in = req_addr[HADDR_W-1:ADDR_W];
  end else begin : g_single
    assign dev_in = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dev_q    <= '0;
    end else if (acc_start) begin
      mem_addr <= req_addr[ADDR_W-1:0];
      dev_q    <= dev_in;
    end
  end

  romrd_seq #(
    .ACT_CYC   (ACT_CYC),
    .LEAD_CYC  (LEAD_CYC),
    .FLOAT_CYC (FLOAT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .ready      (ready),
    .ce_act     (ce_act),
    .oe_act     (oe_act),
    .acc_start  (acc_start),
    .smp_evt    (smp_evt),
    .float_done (float_done)
  );

  romrd_cs_decode #(
    .NDEV (NDEV)
  ) u_dec (
    .ce_act  (ce_act),
    .dev_sel (dev_q),
    .ce_n    (mem_ce_n)
  );

  assign mem_oe_n = !oe_act;

  romrd_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_evt (smp_evt),
    .mem_d   (mem_d),
    .rvalid  (rvalid),
    .rdata   (rdata)
  );

endmodule

// File: rtl/romrd_ctrl_chk.sv
module romrd_ctrl_chk #(
  parameter int NDEV      = 2,
  parameter int ADDR_W    = 19,
  parameter int FLOAT_CYC = 3,
  localparam int SW       = $clog2(FLOAT_CYC + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rvalid,
  input logic [NDEV-1:0]   mem_ce_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [SW-1:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_rel <= SW'(FLOAT_CYC);
    else if (rvalid)                    since_rel <= SW'(1);
    else if (since_rel < SW'(FLOAT_CYC)) since_rel <= since_rel + 1'b1;
  end

  a_r3_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_ce_n) && $past(!(&mem_ce_n))) |-> $stable(mem_addr));

  a_r8_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !(&mem_ce_n));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  a_r5_release_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ((&mem_ce_n) && mem_oe_n && $past(!(&mem_ce_n))));

  a_r6_float_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (since_rel >= SW'(FLOAT_CYC)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((&mem_ce_n) && mem_oe_n));

endmodule

bind romrd_ctrl romrd_ctrl_chk #(
  .NDEV      (NDEV),
  .ADDR_W    (ADDR_W),
  .FLOAT_CYC (FLOAT_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .rvalid   (rvalid),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_addr (mem_addr)
);

// File: tb/romrd_ctrl_tb.sv
`timescale 1ns/1ps
module romrd_ctrl_tb;

  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int ND   = 2;
  localparam int PER  = 20000;
  localparam int TACC = 150000;
  localparam int TCE  = 150000;
  localparam int TOE  = 50000;
  localparam int TDF  = 55000;

  // bench's own cycle arithmetic
  function automatic int cyc(input int t);
    int n;
    n = t / PER;
    if (n * PER < t) n++;
    return n;
  endfunction

  localparam int B_NACC = cyc(TACC);
  localparam int B_NCE  = cyc(TCE);
  localparam int B_NOE  = cyc(TOE);
  localparam int B_NDF  = (cyc(TDF) == 0) ? 1 : cyc(TDF);
  localparam int B_DL   = (B_NACC > B_NCE) ? B_NACC : B_NCE;
  localparam int B_LEAD = (B_DL > B_NOE) ? (B_DL - B_NOE) : 0;
  localparam int B_ACT  = B_DL + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW:0]   req_addr = '0;
  logic          ready;
  logic          rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [ND-1:0] mem_ce_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_d;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  romrd_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .NDEV (ND), .CLK_PS (PER),
    .T_ACC_PS (TACC), .T_CE_PS (TCE), .T_OE_PS (TOE), .T_DF_PS (TDF)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req (req), .req_addr (req_addr),
    .ready (ready), .rvalid (rvalid), .rdata (rdata), .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_d (mem_d)
  );

  function automatic logic [DW-1:0] rom_val(input int dev, input int a);
    return DW'(a * 37 + dev * 101 + 13);
  endfunction

  // memory model: true data only once both access times have elapsed
  int ce_cnt = 0;
  int oe_cnt = 0;
  int sel_dev;

  always_comb begin
    sel_dev = -1;
    for (int i = 0; i < ND; i++) if (!mem_ce_n[i]) sel_dev = i;
  end

  always @(posedge clk) begin
    ce_cnt <= (sel_dev >= 0) ? ce_cnt + 1 : 0;
    oe_cnt <= (sel_dev >= 0 && !mem_oe_n) ? oe_cnt + 1 : 0;
  end

  always_comb begin
    if (sel_dev >= 0 && ce_cnt >= B_NACC && ce_cnt >= B_NCE && oe_cnt >= B_NOE)
      mem_d = rom_val(sel_dev, int'(mem_addr));
    else if (sel_dev >= 0)
      mem_d = ~rom_val(sel_dev, int'(mem_addr));
    else
      mem_d = 8'hA5;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one full read; k counts negedges after the accepting edge
  task automatic do_read(input int dev, input int a, input bit busy_req);
    while (!ready) @(negedge clk);
    req = 1'b1;
    req_addr = {1'(dev), AW'(a)};
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k <= B_ACT + B_NDF; k++) begin
      if (busy_req && k == 2) begin
        req = 1'b1;
        req_addr = {1'(1 - dev), AW'(a + 9)};
      end
      if (busy_req && k == B_ACT + B_NDF - 1) req = 1'b0;
      chk(mem_ce_n[dev] == !(k < B_ACT), "R3 selected ce_n", int'(mem_ce_n[dev]), int'(!(k < B_ACT)));
      chk(mem_ce_n[1 - dev] == 1'b1, "R3 other ce_n", int'(mem_ce_n[1 - dev]), 1);
      if (k < B_ACT) chk(mem_addr == AW'(a), "R3 mem_addr", int'(mem_addr), a);
      chk(mem_oe_n == !(k >= B_LEAD && k < B_ACT), "R4 oe_n timing", int'(mem_oe_n),
          int'(!(k >= B_LEAD && k < B_ACT)));
      chk(rvalid == (k == B_ACT), "R5 rvalid", int'(rvalid), int'(k == B_ACT));
      if (k == B_ACT) chk(rdata == rom_val(dev, a), "R5 rdata", int'(rdata), int'(rom_val(dev, a)));
      chk(ready == (k >= B_ACT + B_NDF), "R6 ready", int'(ready), int'(k >= B_ACT + B_NDF));
      if (k == B_ACT + B_NDF)
        chk(rdata == rom_val(dev, a), "R7 rdata held", int'(rdata), int'(rom_val(dev, a)));
      if (k < B_ACT + B_NDF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(mem_ce_n == '1, "R1 ce_n", int'(mem_ce_n), 3);
    chk(mem_oe_n == 1'b1, "R1 oe_n", int'(mem_oe_n), 1);
    chk(rvalid == 1'b0, "R1 rvalid", int'(rvalid), 0);
    chk(rdata == '0, "R1 rdata", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep over both devices and every address
    for (int d = 0; d < ND; d++)
      for (int a = 0; a < (1 << AW); a++)
        do_read(d, a, 1'b0);

    // R2: request raised while busy must start nothing
    do_read(1, 5, 1'b1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(mem_ce_n == '1, "R2 no cycle from busy req", int'(mem_ce_n), 3);
      chk(ready == 1'b1, "R2 ready stays", int'(ready), 1);
      chk(rdata == rom_val(1, 5), "R7 rdata unchanged", int'(rdata), int'(rom_val(1, 5)));
    end

    // back-to-back reads across devices
    do_read(0, 63, 1'b0);
    do_read(1, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule